// File: doc/BRIEF.md
# AXI4 Slave to Pipelined Wishbone Master Bridge

This block sits between an AXI4 memory-mapped master and a pipelined Wishbone bus. It accepts read and write bursts as an AXI4 slave and turns each beat into one Wishbone transfer. The two buses have the same data width, so one AXI beat is one Wishbone word. A write starts only after its address has been taken. The data beats then feed the Wishbone request stage one word at a time. Reads return every acknowledged word on the read data channel, tagged with the ID of the request.

The bridge serves one burst at a time. When both a write and a read are waiting, the write goes first. The Wishbone cycle line is released between bursts. Inside a burst, requests are pipelined: a new strobe may go out while earlier acknowledges are still pending. Read data passes through a small response queue. The number of read requests in flight is limited so that the queue can always hold every pending answer, even while the AXI master holds off the read data channel. The size, lock, cache, protection and quality-of-service fields are taken in and have no effect.

Top module: `axi_wb_bridge`

## Requirements
- R1: The address channels are ready only while no burst is in progress. When a write address and a read address are both valid, the write is taken first and the read address is held off (ARREADY low) until the write burst has ended.
- R2: Burst type FIXED (code 2'b00) puts the starting address on the Wishbone address for every beat.
- R3: Burst type INCR (code 2'b01) adds DATA_W/8 bytes to the Wishbone address on each beat after the first.
- R4: Burst codes 2'b10 (wrapping) and 2'b11 are not supported. They hold the address as FIXED does, and every response for such a burst is SLVERR (2'b10).
- R5: The size, lock, cache, prot and qos fields of both address channels have no effect on addresses, data or responses.
- R6: No write data beat is accepted before its burst's write address has been accepted. Each accepted beat becomes one Wishbone write that carries WDATA on the data output and WSTRB on the byte selects.
- R7: A write burst gets exactly one B response, raised only after every beat has ended on Wishbone. BID equals AWID. BRESP is OKAY (2'b00), or SLVERR (2'b10) if any beat ended with ERR.
- R8: A read burst gives one R beat per Wishbone transfer, in order. RDATA is the returned word and RID equals ARID. RLAST is high only on the final beat. RRESP is SLVERR (2'b10) on a beat that ended with ERR and OKAY (2'b00) otherwise.
- R9: Requests are pipelined. With no stall and no backpressure, consecutive beats are accepted on consecutive clocks. While STALL is high, the strobe, address, data and write enable hold steady.
- R10: A read burst keeps all data, and keeps it in order, when RREADY is withheld and the slave stalls. A held R beat stays stable until it is taken.
- R11: The strobe is only high with CYC, and CYC goes low for at least one clock between two bursts.
- R12: After reset: no valid output on B or R, WREADY low, CYC and STB low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| axs_awvalid | input | 1 | Write address valid |
| axs_awready | output | 1 | Write address ready |
| axs_awid | input | ID_W | Write transaction ID |
| axs_awaddr | input | ADDR_W | Write start byte address |
| axs_awlen | input | 8 | Write beats minus one |
| axs_awsize | input | 3 | Write beat size (ignored) |
| axs_awburst | input | 2 | Write burst type |
| axs_awlock | input | 1 | Write lock (ignored) |
| axs_awcache | input | 4 | Write cache attributes (ignored) |
| axs_awprot | input | 3 | Write protection (ignored) |
| axs_awqos | input | 4 | Write QoS (ignored) |
| axs_wvalid | input | 1 | Write data valid |
| axs_wready | output | 1 | Write data ready |
| axs_wdata | input | DATA_W | Write data |
| axs_wstrb | input | DATA_W/8 | Write byte strobes |
| axs_wlast | input | 1 | Last write beat (beats are counted from AWLEN instead) |
| axs_bvalid | output | 1 | Write response valid |
| axs_bready | input | 1 | Write response ready |
| axs_bid | output | ID_W | Write response ID |
| axs_bresp | output | 2 | Write response code |
| axs_arvalid | input | 1 | Read address valid |
| axs_arready | output | 1 | Read address ready |
| axs_arid | input | ID_W | Read transaction ID |
| axs_araddr | input | ADDR_W | Read start byte address |
| axs_arlen | input | 8 | Read beats minus one |
| axs_arsize | input | 3 | Read beat size (ignored) |
| axs_arburst | input | 2 | Read burst type |
| axs_arlock | input | 1 | Read lock (ignored) |
| axs_arcache | input | 4 | Read cache attributes (ignored) |
| axs_arprot | input | 3 | Read protection (ignored) |
| axs_arqos | input | 4 | Read QoS (ignored) |
| axs_rvalid | output | 1 | Read data valid |
| axs_rready | input | 1 | Read data ready |
| axs_rid | output | ID_W | Read data ID |
| axs_rdata | output | DATA_W | Read data |
| axs_rresp | output | 2 | Read response code |
| axs_rlast | output | 1 | Final read beat |
| wbm_cyc | output | 1 | Wishbone cycle |
| wbm_stb | output | 1 | Wishbone strobe |
| wbm_we | output | 1 | Wishbone write enable |
| wbm_adr | output | ADDR_W | Wishbone byte address |
| wbm_dat_o | output | DATA_W | Wishbone write data |
| wbm_sel | output | DATA_W/8 | Wishbone byte selects |
| wbm_stall | input | 1 | Wishbone stall |
| wbm_ack | input | 1 | Wishbone acknowledge |
| wbm_err | input | 1 | Wishbone error |
| wbm_dat_i | input | DATA_W | Wishbone read data |

## Verification
The bench checks the address sequence of FIXED, INCR and unsupported bursts at the Wishbone side. A design that stepped the address for FIXED, used AxSIZE for the step, or wrapped would log the wrong address on some beat. Errors are injected in the middle of bursts. A write error flag that is not held sticky shows up as an OKAY B response, and a read error flag that leaks into the next beat shows up as SLVERR on a clean beat. A B sent early, before all acknowledges, is caught by counting Wishbone terminations when B appears. The bench also exercises read backpressure with stall, and a write and read arriving in the same clock. A bridge that dropped beats under backpressure, let the read win, or kept CYC high across bursts would fail those checks.

// File: rtl/axi_wb_pkg.sv
package axi_wb_pkg;

    localparam int AXLEN_W = 8;

    typedef enum logic [1:0] {
        BT_FIXED = 2'b00,
        BT_INCR  = 2'b01,
        BT_WRAP  = 2'b10,
        BT_RSVD  = 2'b11
    } burst_e;

    typedef enum logic [1:0] {
        RSP_OKAY   = 2'b00,
        RSP_SLVERR = 2'b10
    } resp_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_WRITE,
        ST_READ,
        ST_FINISH
    } state_e;

    typedef struct packed {
        logic               is_write;
        logic               hold_addr;
        logic               bad_burst;
        logic [AXLEN_W-1:0] len;
    } cmd_ctrl_t;

    function automatic cmd_ctrl_t decode_cmd(input logic wr,
                                             input logic [1:0] burst,
                                             input logic [AXLEN_W-1:0] len);
        cmd_ctrl_t c;
        c.is_write  = wr;
        c.hold_addr = (burst != BT_INCR);
        c.bad_burst = burst[1];
        c.len       = len;
        return c;
    endfunction

endpackage

// File: rtl/axi_wb_cmd_sel.sv
module axi_wb_cmd_sel
    import axi_wb_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int ID_W   = 4
) (
    input  logic               idle,
    input  logic               awvalid,
    input  logic [ID_W-1:0]    awid,
    input  logic [ADDR_W-1:0]  awaddr,
    input  logic [AXLEN_W-1:0] awlen,
    input  logic [1:0]         awburst,
    input  logic               arvalid,
    input  logic [ID_W-1:0]    arid,
    input  logic [ADDR_W-1:0]  araddr,
    input  logic [AXLEN_W-1:0] arlen,
    input  logic [1:0]         arburst,
    output logic               awready,
    output logic               arready,
    output logic               take,
    output cmd_ctrl_t          cmd,
    output logic [ID_W-1:0]    cmd_id,
    output logic [ADDR_W-1:0]  cmd_addr
);
    // Write has fixed priority over read.
    always_comb begin
        awready  = idle;
        arready  = idle && !awvalid;
        take     = (awvalid && awready) || (arvalid && arready);
        if (awvalid) begin
            cmd      = decode_cmd(1'b1, awburst, awlen);
            cmd_id   = awid;
            cmd_addr = awaddr;
        end else begin
            cmd      = decode_cmd(1'b0, arburst, arlen);
            cmd_id   = arid;
            cmd_addr = araddr;
        end
    end
endmodule

// File: rtl/axi_wb_beat_issue.sv
module axi_wb_beat_issue
    import axi_wb_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int CNT_W  = AXLEN_W + 1
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                load,
    input  cmd_ctrl_t           load_ctrl,
    input  logic [ADDR_W-1:0]   load_addr,
    input  logic                active,
    input  logic                read_credit,
    input  logic                wvalid,
    input  logic [DATA_W-1:0]   wdata,
    input  logic [DATA_W/8-1:0] wstrb,
    input  logic                wb_stall,
    output logic                wready,
    output logic                wb_stb,
    output logic                wb_we,
    output logic [ADDR_W-1:0]   wb_adr,
    output logic [DATA_W-1:0]   wb_dat,
    output logic [DATA_W/8-1:0] wb_sel,
    output logic [CNT_W-1:0]    beats_left
);
    localparam int SEL_W = DATA_W / 8;
    localparam logic [ADDR_W-1:0] STEP = ADDR_W'(SEL_W);

    logic [ADDR_W-1:0] next_adr;
    logic              hold_q;
    logic              slot_free;
    logic              want;
    logic              fire;

    always_comb begin
        slot_free = !wb_stb || !wb_stall;
        want      = active && (beats_left != '0) && slot_free;
        wready    = want && wb_we;
        fire      = want && (wb_we ? wvalid : read_credit);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            next_adr   <= '0;
            hold_q     <= 1'b0;
            wb_we      <= 1'b0;
            wb_stb     <= 1'b0;
            wb_adr     <= '0;
            wb_dat     <= '0;
            wb_sel     <= '0;
            beats_left <= '0;
        end else if (load) begin
            next_adr   <= load_addr;
            hold_q     <= load_ctrl.hold_addr;
            wb_we      <= load_ctrl.is_write;
            beats_left <= CNT_W'(load_ctrl.len) + CNT_W'(1);
        end else if (fire) begin
            wb_stb     <= 1'b1;
            wb_adr     <= next_adr;
            wb_dat     <= wb_we ? wdata : '0;
            wb_sel     <= wb_we ? wstrb : '1;
            next_adr   <= hold_q ? next_adr : next_adr + STEP;
            beats_left <= beats_left - CNT_W'(1);
        end else if (!wb_stall) begin
            wb_stb     <= 1'b0;
        end
    end
endmodule

// File: rtl/axi_wb_rsp_fifo.sv
module axi_wb_rsp_fifo #(
    parameter int W     = 34,
    parameter int DEPTH = 4
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       push,
    input  logic [W-1:0]               din,
    input  logic                       pop,
    output logic [W-1:0]               dout,
    output logic                       empty,
    output logic [$clog2(DEPTH+1)-1:0] count
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW    = $clog2(DEPTH + 1);
    localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

    logic [W-1:0]     store [DEPTH];
    logic [PTR_W-1:0] wr_ptr;
    logic [PTR_W-1:0] rd_ptr;

    assign empty = (count == '0);
    assign dout  = store[rd_ptr];

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) begin
                store[wr_ptr] <= din;
                wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + PTR_W'(1);
            end
            if (pop) begin
                rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + PTR_W'(1);
            end
            case ({push, pop})
                2'b10:   count <= count + CW'(1);
                2'b01:   count <= count - CW'(1);
                default: count <= count;
            endcase
        end
    end
endmodule

// File: rtl/axi_wb_bridge.sv
module axi_wb_bridge
    import axi_wb_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int DATA_W    = 32,
    parameter int ID_W      = 4,
    parameter int RSP_DEPTH = 4
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                axs_awvalid,
    output logic                axs_awready,
    input  logic [ID_W-1:0]     axs_awid,
    input  logic [ADDR_W-1:0]   axs_awaddr,
    input  logic [7:0]          axs_awlen,
    input  logic [2:0]          axs_awsize,
    input  logic [1:0]          axs_awburst,
    input  logic                axs_awlock,
    input  logic [3:0]          axs_awcache,
    input  logic [2:0]          axs_awprot,
    input  logic [3:0]          axs_awqos,
    input  logic                axs_wvalid,
    output logic                axs_wready,
    input  logic [DATA_W-1:0]   axs_wdata,
    input  logic [DATA_W/8-1:0] axs_wstrb,
    input  logic                axs_wlast,
    output logic                axs_bvalid,
    input  logic                axs_bready,
    output logic [ID_W-1:0]     axs_bid,
    output logic [1:0]          axs_bresp,
    input  logic                axs_arvalid,
    output logic                axs_arready,
    input  logic [ID_W-1:0]     axs_arid,
    input  logic [ADDR_W-1:0]   axs_araddr,
    input  logic [7:0]          axs_arlen,
    input  logic [2:0]          axs_arsize,
    input  logic [1:0]          axs_arburst,
    input  logic                axs_arlock,
    input  logic [3:0]          axs_arcache,
    input  logic [2:0]          axs_arprot,
    input  logic [3:0]          axs_arqos,
    output logic                axs_rvalid,
    input  logic                axs_rready,
    output logic [ID_W-1:0]     axs_rid,
    output logic [DATA_W-1:0]   axs_rdata,
    output logic [1:0]          axs_rresp,
    output logic                axs_rlast,
    output logic                wbm_cyc,
    output logic                wbm_stb,
    output logic                wbm_we,
    output logic [ADDR_W-1:0]   wbm_adr,
    output logic [DATA_W-1:0]   wbm_dat_o,
    output logic [DATA_W/8-1:0] wbm_sel,
    input  logic                wbm_stall,
    input  logic                wbm_ack,
    input  logic                wbm_err,
    input  logic [DATA_W-1:0]   wbm_dat_i
);
    localparam int CNT_W  = AXLEN_W + 1;
    localparam int FIFO_W = DATA_W + 2;
    localparam int FC_W   = $clog2(RSP_DEPTH + 1);

    // Fields that are accepted but have no effect on behaviour.
    logic unused_fields;
    assign unused_fields = ^{axs_awsize, axs_awlock, axs_awcache, axs_awprot, axs_awqos,
                             axs_arsize, axs_arlock, axs_arcache, axs_arprot, axs_arqos,
                             axs_wlast};

    state_e            st;
    cmd_ctrl_t         ctrl;
    logic [ID_W-1:0]   id_q;
    logic              err_q;
    logic [CNT_W-1:0]  done_cnt;

    logic              idle;
    logic              busy;
    logic              take;
    cmd_ctrl_t         cmd;
    logic [ID_W-1:0]   cmd_id;
    logic [ADDR_W-1:0] cmd_addr;

    logic [CNT_W-1:0]  beats_left;
    logic [CNT_W-1:0]  total;
    logic [CNT_W-1:0]  issued;
    logic [CNT_W-1:0]  reserved;
    logic              credit;
    logic              term;
    logic              last_term;

    logic              f_push;
    logic              f_pop;
    logic              f_empty;
    logic [FIFO_W-1:0] f_din;
    logic [FIFO_W-1:0] f_dout;
    logic [FC_W-1:0]   f_count;

    assign idle = (st == ST_IDLE);
    assign busy = (st == ST_WRITE) || (st == ST_READ);

    axi_wb_cmd_sel #(.ADDR_W(ADDR_W), .ID_W(ID_W)) u_sel (
        .idle    (idle),
        .awvalid (axs_awvalid),
        .awid    (axs_awid),
        .awaddr  (axs_awaddr),
        .awlen   (axs_awlen),
        .awburst (axs_awburst),
        .arvalid (axs_arvalid),
        .arid    (axs_arid),
        .araddr  (axs_araddr),
        .arlen   (axs_arlen),
        .arburst (axs_arburst),
        .awready (axs_awready),
        .arready (axs_arready),
        .take    (take),
        .cmd     (cmd),
        .cmd_id  (cmd_id),
        .cmd_addr(cmd_addr)
    );

    always_comb begin
        total     = CNT_W'(ctrl.len) + CNT_W'(1);
        issued    = total - beats_left;
        reserved  = (issued - done_cnt) + CNT_W'(f_count);
        credit    = reserved < CNT_W'(RSP_DEPTH);
        term      = busy && (wbm_ack || wbm_err);
        last_term = term && (done_cnt == total - CNT_W'(1));
    end

    axi_wb_beat_issue #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_issue (
        .clk        (clk),
        .rst        (rst),
        .load       (take),
        .load_ctrl  (cmd),
        .load_addr  (cmd_addr),
        .active     (busy),
        .read_credit(credit),
        .wvalid     (axs_wvalid),
        .wdata      (axs_wdata),
        .wstrb      (axs_wstrb),
        .wb_stall   (wbm_stall),
        .wready     (axs_wready),
        .wb_stb     (wbm_stb),
        .wb_we      (wbm_we),
        .wb_adr     (wbm_adr),
        .wb_dat     (wbm_dat_o),
        .wb_sel     (wbm_sel),
        .beats_left (beats_left)
    );

    // Read response queue entry: {data, error, last}.
    assign f_push = term && (st == ST_READ);
    assign f_din  = {wbm_dat_i, wbm_err || ctrl.bad_burst, last_term};
    assign f_pop  = axs_rvalid && axs_rready;

    axi_wb_rsp_fifo #(.W(FIFO_W), .DEPTH(RSP_DEPTH)) u_rsp (
        .clk  (clk),
        .rst  (rst),
        .push (f_push),
        .din  (f_din),
        .pop  (f_pop),
        .dout (f_dout),
        .empty(f_empty),
        .count(f_count)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= ST_IDLE;
            ctrl     <= '0;
            id_q     <= '0;
            err_q    <= 1'b0;
            done_cnt <= '0;
        end else begin
            case (st)
                ST_IDLE: begin
                    if (take) begin
                        ctrl     <= cmd;
                        id_q     <= cmd_id;
                        err_q    <= cmd.bad_burst;
                        done_cnt <= '0;
                        st       <= cmd.is_write ? ST_WRITE : ST_READ;
                    end
                end
                ST_WRITE, ST_READ: begin
                    if (term) done_cnt <= done_cnt + CNT_W'(1);
                    if (wbm_err) err_q <= 1'b1;
                    if (last_term) st <= ST_FINISH;
                end
                default: begin
                    if (ctrl.is_write ? axs_bready : f_empty) st <= ST_IDLE;
                end
            endcase
        end
    end

    always_comb begin
        wbm_cyc    = busy;
        axs_bvalid = (st == ST_FINISH) && ctrl.is_write;
        axs_bid    = id_q;
        axs_bresp  = err_q ? RSP_SLVERR : RSP_OKAY;
        axs_rvalid = !f_empty;
        axs_rid    = id_q;
        axs_rdata  = f_dout[FIFO_W-1:2];
        axs_rresp  = f_dout[1] ? RSP_SLVERR : RSP_OKAY;
        axs_rlast  = f_dout[0];
    end
endmodule

// File: rtl/axi_wb_bridge_chk.sv
module axi_wb_bridge_chk #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int ID_W   = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              axs_awvalid,
    input logic              axs_awready,
    input logic              axs_arready,
    input logic              axs_wready,
    input logic              axs_bvalid,
    input logic              axs_bready,
    input logic [ID_W-1:0]   axs_bid,
    input logic [1:0]        axs_bresp,
    input logic              axs_rvalid,
    input logic              axs_rready,
    input logic [ID_W-1:0]   axs_rid,
    input logic [DATA_W-1:0] axs_rdata,
    input logic [1:0]        axs_rresp,
    input logic              axs_rlast,
    input logic              wbm_cyc,
    input logic              wbm_stb,
    input logic              wbm_we,
    input logic [ADDR_W-1:0] wbm_adr,
    input logic [DATA_W-1:0] wbm_dat_o,
    input logic              wbm_stall
);
    // R1: address channels only open between bursts
    a_r1_ready_only_idle: assert property (@(posedge clk) disable iff (rst)
        (axs_awready || axs_arready) |-> !wbm_cyc && !axs_bvalid);

    // R1: write wins over a simultaneous read
    a_r1_write_first: assert property (@(posedge clk) disable iff (rst)
        axs_arready |-> !axs_awvalid);

    // R6: data beats only taken inside a write burst
    a_r6_w_in_write: assert property (@(posedge clk) disable iff (rst)
        axs_wready |-> wbm_cyc && wbm_we);

    // R9: request held while the slave stalls
    a_r9_stall_hold: assert property (@(posedge clk) disable iff (rst)
        (wbm_stb && wbm_stall) |=> wbm_stb && $stable(wbm_adr) && $stable(wbm_dat_o) && $stable(wbm_we));

    // R11: strobe only inside a cycle
    a_r11_stb_in_cyc: assert property (@(posedge clk) disable iff (rst)
        wbm_stb |-> wbm_cyc);

    // R7: B response held until taken, after the bus cycle has closed
    a_r7_b_hold: assert property (@(posedge clk) disable iff (rst)
        (axs_bvalid && !axs_bready) |=> axs_bvalid && $stable(axs_bid) && $stable(axs_bresp));

    a_r7_b_after_cyc: assert property (@(posedge clk) disable iff (rst)
        axs_bvalid |-> !wbm_cyc);

    // R10: R beat held until taken
    a_r10_r_hold: assert property (@(posedge clk) disable iff (rst)
        (axs_rvalid && !axs_rready) |=> axs_rvalid && $stable(axs_rdata) && $stable(axs_rid)
                                        && $stable(axs_rresp) && $stable(axs_rlast));
endmodule

bind axi_wb_bridge axi_wb_bridge_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .ID_W(ID_W)) u_chk (.*);

// File: tb/tb_axi_wb_bridge.sv
module tb_axi_wb_bridge;
    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W = 32;
    localparam int DATA_W = 32;
    localparam int ID_W   = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #(CLK_PERIOD/2) clk = ~clk;

    logic              axs_awvalid = 0, axs_awready;
    logic [ID_W-1:0]   axs_awid = 0;
    logic [ADDR_W-1:0] axs_awaddr = 0;
    logic [7:0]        axs_awlen = 0;
    logic [2:0]        axs_awsize = 3'd2;
    logic [1:0]        axs_awburst = 0;
    logic              axs_awlock = 0;
    logic [3:0]        axs_awcache = 0;
    logic [2:0]        axs_awprot = 0;
    logic [3:0]        axs_awqos = 0;
    logic              axs_wvalid = 0, axs_wready;
    logic [DATA_W-1:0] axs_wdata = 0;
    logic [3:0]        axs_wstrb = 0;
    logic              axs_wlast = 0;
    logic              axs_bvalid, axs_bready = 0;
    logic [ID_W-1:0]   axs_bid;
    logic [1:0]        axs_bresp;
    logic              axs_arvalid = 0, axs_arready;
    logic [ID_W-1:0]   axs_arid = 0;
    logic [ADDR_W-1:0] axs_araddr = 0;
    logic [7:0]        axs_arlen = 0;
    logic [2:0]        axs_arsize = 3'd2;
    logic [1:0]        axs_arburst = 0;
    logic              axs_arlock = 0;
    logic [3:0]        axs_arcache = 0;
    logic [2:0]        axs_arprot = 0;
    logic [3:0]        axs_arqos = 0;
    logic              axs_rvalid, axs_rready = 0;
    logic [ID_W-1:0]   axs_rid;
    logic [DATA_W-1:0] axs_rdata;
    logic [1:0]        axs_rresp;
    logic              axs_rlast;
    logic              wbm_cyc, wbm_stb, wbm_we;
    logic [ADDR_W-1:0] wbm_adr;
    logic [DATA_W-1:0] wbm_dat_o;
    logic [3:0]        wbm_sel;
    logic              wbm_stall;
    logic              wbm_ack = 0, wbm_err = 0;
    logic [DATA_W-1:0] wbm_dat_i = 0;

    axi_wb_bridge #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .ID_W(ID_W), .RSP_DEPTH(4)) dut (.*);

    // ---------------- Wishbone slave model and bus monitor ----------------
    logic [31:0] mem [64];
    logic        stall_on = 0;
    logic [3:0]  stall_ctr = 0;
    logic        err_en = 0;
    logic [5:0]  err_word = 0;
    logic        cyc_q = 0;
    int          cycle = 0;
    int          nlog = 0, ncyc = 0, nterm = 0;
    logic [31:0] log_adr [256];
    logic [31:0] log_dat [256];
    logic [3:0]  log_sel [256];
    logic        log_we  [256];
    int          log_cyc [256];

    assign wbm_stall = stall_on && (stall_ctr[0] ^ stall_ctr[2]);
    wire [5:0] widx = wbm_adr[7:2];

    always_ff @(posedge clk) begin
        cycle     <= cycle + 1;
        stall_ctr <= stall_ctr + 4'd1;
        if (rst) begin
            for (int i = 0; i < 64; i++) mem[i] <= 32'hA500_0000 + 32'(i);
            wbm_ack <= 0; wbm_err <= 0; nlog <= 0; ncyc <= 0; nterm <= 0; cyc_q <= 0;
        end else begin
            wbm_ack <= 0; wbm_err <= 0;
            cyc_q <= wbm_cyc;
            if (wbm_cyc && !cyc_q) ncyc <= ncyc + 1;
            if (wbm_ack || wbm_err) nterm <= nterm + 1;
            if (wbm_cyc && wbm_stb && !wbm_stall) begin
                if (err_en && widx == err_word) wbm_err <= 1;
                else begin
                    wbm_ack <= 1;
                    if (wbm_we) begin
                        for (int b = 0; b < 4; b++)
                            if (wbm_sel[b]) mem[widx][8*b +: 8] <= wbm_dat_o[8*b +: 8];
                    end else wbm_dat_i <= mem[widx];
                end
                log_adr[nlog[7:0]] <= wbm_adr;
                log_dat[nlog[7:0]] <= wbm_dat_o;
                log_sel[nlog[7:0]] <= wbm_sel;
                log_we[nlog[7:0]]  <= wbm_we;
                log_cyc[nlog[7:0]] <= cycle;
                nlog <= nlog + 1;
            end
        end
    end

    // ---------------- bookkeeping ----------------
    int nchk = 0, nbad = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        nchk++;
        if (!ok) begin
            nbad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // ---------------- AXI master helpers ----------------
    task automatic aw_send(input logic [3:0] id, input logic [31:0] a, input logic [7:0] len,
                           input logic [1:0] bt, input logic [2:0] sz, input logic odd);
        @(negedge clk);
        axs_awid = id; axs_awaddr = a; axs_awlen = len; axs_awburst = bt; axs_awsize = sz;
        axs_awlock = odd; axs_awcache = odd ? 4'hF : 4'h0; axs_awprot = odd ? 3'h7 : 3'h0;
        axs_awqos = odd ? 4'hF : 4'h0;
        axs_awvalid = 1; #1;
        while (!axs_awready) begin @(negedge clk); #1; end
        @(posedge clk); #1 axs_awvalid = 0;
    endtask

    task automatic ar_send(input logic [3:0] id, input logic [31:0] a, input logic [7:0] len,
                           input logic [1:0] bt, input logic [2:0] sz, input logic odd);
        @(negedge clk);
        axs_arid = id; axs_araddr = a; axs_arlen = len; axs_arburst = bt; axs_arsize = sz;
        axs_arlock = odd; axs_arcache = odd ? 4'hF : 4'h0; axs_arprot = odd ? 3'h7 : 3'h0;
        axs_arqos = odd ? 4'hF : 4'h0;
        axs_arvalid = 1; #1;
        while (!axs_arready) begin @(negedge clk); #1; end
        @(posedge clk); #1 axs_arvalid = 0;
    endtask

    task automatic w_send(input int n, input logic [31:0] base, input logic [3:0] strb);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            axs_wvalid = 1; axs_wdata = base + 32'(k); axs_wstrb = strb; axs_wlast = (k == n-1);
            #1;
            while (!axs_wready) begin @(negedge clk); #1; end
            @(posedge clk); #1 axs_wvalid = 0;
        end
    endtask

    logic [3:0] got_bid; logic [1:0] got_bresp; int got_terms;
    task automatic b_get();
        @(negedge clk); axs_bready = 1; #1;
        while (!axs_bvalid) begin @(negedge clk); #1; end
        got_bid = axs_bid; got_bresp = axs_bresp; got_terms = nterm;
        @(posedge clk); #1 axs_bready = 0;
    endtask

    logic [31:0] rd_dat [64]; logic [1:0] rd_resp [64]; logic rd_last [64]; logic [3:0] rd_id [64];
    task automatic r_get(input int n, input bit bp);
        int cnt = 0;
        while (cnt < n) begin
            @(negedge clk);
            axs_rready = bp ? ~axs_rready : 1'b1;
            #1;
            if (axs_rvalid && axs_rready) begin
                rd_dat[cnt] = axs_rdata; rd_resp[cnt] = axs_rresp;
                rd_last[cnt] = axs_rlast; rd_id[cnt] = axs_rid;
                cnt++;
            end
        end
        @(negedge clk); axs_rready = 0;
    endtask

    // ---------------- scenarios ----------------
    task automatic t_reset();
        @(negedge clk); #1;
        check(!axs_bvalid && !axs_rvalid && !axs_wready, "R12", "valid/ready after reset",
              {axs_bvalid, axs_rvalid, axs_wready}, 0);
        check(!wbm_cyc && !wbm_stb, "R12", "cyc/stb after reset", {wbm_cyc, wbm_stb}, 0);
    endtask

    task automatic t_incr_write();
        int base = nlog; int tb0 = nterm;
        // R6: data offered before any address must not be taken
        @(negedge clk); axs_wvalid = 1; axs_wdata = 32'hDEAD; axs_wstrb = 4'hF;
        for (int i = 0; i < 3; i++) begin
            #1 check(!axs_wready, "R6", "wready before AW", axs_wready, 0);
            @(negedge clk);
        end
        axs_wvalid = 0;
        check(nlog == base, "R6", "no WB write before AW", 64'(nlog - base), 0);
        aw_send(4'd3, 32'h40, 8'd3, 2'b01, 3'd2, 0);
        w_send(4, 32'h1000, 4'hC);
        b_get();
        for (int k = 0; k < 4; k++) begin
            check(log_adr[base+k] == 32'h40 + 32'(4*k), "R3", "INCR write address", log_adr[base+k], 32'h40 + 32'(4*k));
            check(log_dat[base+k] == 32'h1000 + 32'(k) && log_sel[base+k] == 4'hC && log_we[base+k],
                  "R6", "write data/sel", {log_dat[base+k], log_sel[base+k]}, {32'h1000 + 32'(k), 4'hC});
        end
        check(got_bid == 4'd3 && got_bresp == 2'b00, "R7", "B id/resp", {got_bid, got_bresp}, {4'd3, 2'b00});
        check(got_terms - tb0 == 4, "R7", "B after all acks", 64'(got_terms - tb0), 4);
        @(negedge clk); #1 check(!axs_bvalid, "R7", "single B", axs_bvalid, 0);
    endtask

    task automatic t_fixed_read();
        int base = nlog;
        ar_send(4'd5, 32'h80, 8'd3, 2'b00, 3'd2, 0);
        r_get(4, 0);
        for (int k = 0; k < 4; k++) begin
            check(log_adr[base+k] == 32'h80, "R2", "FIXED read address", log_adr[base+k], 32'h80);
            check(rd_dat[k] == mem[32] && rd_id[k] == 4'd5 && rd_resp[k] == 2'b00,
                  "R8", "read beat data/id/resp", {rd_dat[k], rd_id[k], rd_resp[k]}, {mem[32], 4'd5, 2'b00});
            check(rd_last[k] == (k == 3), "R8", "RLAST position", rd_last[k], (k == 3));
        end
    endtask

    task automatic t_pipelined();
        int base = nlog;
        ar_send(4'd1, 32'h10, 8'd3, 2'b01, 3'd2, 0);
        r_get(4, 0);
        for (int k = 1; k < 4; k++)
            check(log_cyc[base+k] - log_cyc[base+k-1] == 1, "R9", "back-to-back accept",
                  64'(log_cyc[base+k] - log_cyc[base+k-1]), 1);
        for (int k = 0; k < 4; k++)
            check(rd_dat[k] == mem[4+k], "R3", "INCR read data", rd_dat[k], mem[4+k]);
    endtask

    task automatic t_backpressure();
        stall_on = 1;
        ar_send(4'd9, 32'h00, 8'd7, 2'b01, 3'd2, 0);
        r_get(8, 1);
        stall_on = 0;
        for (int k = 0; k < 8; k++)
            check(rd_dat[k] == mem[k] && rd_last[k] == (k == 7) && rd_id[k] == 4'd9,
                  "R10", "beat under backpressure", {rd_dat[k], rd_last[k]}, {mem[k], k == 7});
    endtask

    task automatic t_unsupported();
        int base = nlog;
        aw_send(4'd2, 32'hC0, 8'd1, 2'b10, 3'd2, 0);
        w_send(2, 32'h2000, 4'hF);
        b_get();
        check(log_adr[base] == 32'hC0 && log_adr[base+1] == 32'hC0, "R4", "WRAP address held",
              log_adr[base+1], 32'hC0);
        check(got_bresp == 2'b10, "R4", "WRAP write SLVERR", got_bresp, 2'b10);
        base = nlog;
        ar_send(4'd4, 32'hC4, 8'd1, 2'b11, 3'd2, 0);
        r_get(2, 0);
        check(log_adr[base+1] == 32'hC4, "R4", "reserved burst address held", log_adr[base+1], 32'hC4);
        check(rd_resp[0] == 2'b10 && rd_resp[1] == 2'b10, "R4", "reserved burst SLVERR",
              {rd_resp[0], rd_resp[1]}, 4'b1010);
    endtask

    task automatic t_ignored();
        int base = nlog;
        aw_send(4'd7, 32'h20, 8'd2, 2'b01, 3'd0, 1);
        w_send(3, 32'h3000, 4'hF);
        b_get();
        for (int k = 0; k < 3; k++)
            check(log_adr[base+k] == 32'h20 + 32'(4*k), "R5", "size/attrs do not change step",
                  log_adr[base+k], 32'h20 + 32'(4*k));
        check(got_bresp == 2'b00 && got_bid == 4'd7, "R5", "attrs do not change B", {got_bid, got_bresp}, {4'd7, 2'b00});
        ar_send(4'd6, 32'h20, 8'd2, 2'b01, 3'd1, 1);
        r_get(3, 0);
        for (int k = 0; k < 3; k++)
            check(rd_dat[k] == 32'h3000 + 32'(k) && rd_resp[k] == 2'b00, "R5", "attrs do not change read",
                  rd_dat[k], 32'h3000 + 32'(k));
    endtask

    task automatic t_errors();
        int tb0 = nterm;
        err_en = 1; err_word = 6'd18;
        aw_send(4'd8, 32'h40, 8'd3, 2'b01, 3'd2, 0);
        w_send(4, 32'h4000, 4'hF);
        b_get();
        check(got_bresp == 2'b10, "R7", "sticky write error", got_bresp, 2'b10);
        check(got_terms - tb0 == 4, "R7", "B after all beats with error", 64'(got_terms - tb0), 4);
        ar_send(4'd10, 32'h44, 8'd2, 2'b01, 3'd2, 0);
        r_get(3, 0);
        check(rd_resp[0] == 2'b00 && rd_resp[1] == 2'b10 && rd_resp[2] == 2'b00, "R8",
              "per-beat read error", {rd_resp[0], rd_resp[1], rd_resp[2]}, 6'b001000);
        err_en = 0;
    endtask

    task automatic t_priority();
        int c0 = ncyc; int base = nlog;
        @(negedge clk);
        axs_awid = 4'd11; axs_awaddr = 32'h60; axs_awlen = 0; axs_awburst = 2'b01; axs_awsize = 3'd2;
        axs_awlock = 0; axs_awcache = 0; axs_awprot = 0; axs_awqos = 0;
        axs_arid = 4'd12; axs_araddr = 32'h60; axs_arlen = 0; axs_arburst = 2'b01; axs_arsize = 3'd2;
        axs_arlock = 0; axs_arcache = 0; axs_arprot = 0; axs_arqos = 0;
        axs_awvalid = 1; axs_arvalid = 1; #1;
        check(axs_awready && !axs_arready, "R1", "write wins", {axs_awready, axs_arready}, 2'b10);
        @(posedge clk); #1 axs_awvalid = 0;
        @(negedge clk); #1 check(!axs_arready, "R1", "read held during write", axs_arready, 0);
        w_send(1, 32'h5555, 4'hF);
        b_get();
        #1;
        while (!axs_arready) begin @(negedge clk); #1; end
        @(posedge clk); #1 axs_arvalid = 0;
        r_get(1, 0);
        check(rd_dat[0] == 32'h5555 && rd_id[0] == 4'd12, "R1", "read after write", rd_dat[0], 32'h5555);
        check(log_we[base] && !log_we[base+1], "R1", "write issued before read",
              {log_we[base], log_we[base+1]}, 2'b10);
        check(ncyc - c0 == 2, "R11", "CYC dropped between bursts", 64'(ncyc - c0), 2);
    endtask

    initial begin
        repeat (4) @(posedge clk);
        #1 rst = 0;
        t_reset();
        t_incr_write();
        t_fixed_read();
        t_pipelined();
        t_backpressure();
        t_unsupported();
        t_ignored();
        t_errors();
        t_priority();
        repeat (3) @(posedge clk);
        $display("test done: total=%0d bad=%0d", nchk, nbad);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        nchk++; nbad++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("test done: total=%0d bad=%0d", nchk, nbad);
        $finish;
    end
endmodule